// File: doc/BRIEF.md
# CHR-Bank-Driven Nametable Page Selector

This block sits on the cartridge side of a tile-based video system. It holds the eight 1 KB character bank registers and the bank-select state of a scanline-counting style banking controller. It turns each video address into a bank number on an external character ROM address bus. It also owns a 2 KB nametable RAM, split into two 1 KB pages. No mirroring register decides which page a nametable access reaches. The page is the top bit of the character bank that the current bank mode places at the same 1 KB slot, as if the nametable address were a pattern fetch.

The CPU writes the bank-select and bank-data registers through a narrow write port. The port sees only the three high address lines and the lowest address line. The video side presents an address with a read or write strobe. The block decodes nametable accesses, asserts a hit flag when it serves one, and returns read data one clock after the read strobe.

Top module: `nbc_top`

## Requirements
- R1: After reset, every bank register, the register index and the bank mode are zero. A pattern address of 0x0000 then shows bank 0x00 and 0x0400 shows bank 0x01.
- R2: A CPU write with address lines A15..A13 = 3'b100 and A0 = 0 stores data bits 2:0 as the register index and data bit 7 as the bank mode (0 or 1).
- R3: A CPU write with A15..A13 = 3'b100 and A0 = 1 loads all 8 data bits into the register named by the last index write.
- R4: In mode 0, 1 KB slots 0/1 show R0 with bit 0 forced to 0/1, slots 2/3 show R1 with bit 0 forced to 0/1, and slots 4..7 show R2..R5. The slot is video address bits 12:10.
- R5: In mode 1, slots 0..3 show R2..R5, and slots 4..7 show the R0/R1 pairs with bit 0 forced as in R4.
- R6: The hit flag is high exactly when the video address, ANDed with 0x2FFF, falls in 0x2000..0x2FFF (video address bit 13 set).
- R7: In mode 0, nametable quadrants 0 and 1 (address bits 11:10) use bit 7 of R0 as the page, and quadrants 2 and 3 use bit 7 of R1.
- R8: In mode 1, nametable quadrants 0, 1, 2 and 3 use bit 7 of R2, R3, R4 and R5 as the page.
- R9: CPU writes whose A15..A13 are not 3'b100 (for example the mirroring address 0xA000) change no register, index or mode, so page routing is unchanged.
- R10: A nametable write stores its byte at offset bits 9:0 of the selected page. A read returns that page's byte on the data output one clock after the strobe. The two pages keep their contents independently as bit 7 changes.
- R11: Reset does not clear nametable RAM contents.
- R12: A write strobe without a hit leaves the nametable RAM unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_a_top | input | 3 | CPU address lines A15..A13 |
| cpu_a0 | input | 1 | CPU address line A0 |
| cpu_wdata | input | 8 | CPU write data |
| vid_addr | input | 14 | Video address |
| vid_re | input | 1 | Video read strobe |
| vid_we | input | 1 | Video write strobe |
| vid_wdata | input | 8 | Video write data |
| vid_rdata | output | 8 | Nametable read data, one clock after vid_re |
| nt_hit | output | 1 | Block serves the current video access |
| chr_bank | output | 8 | 1 KB character bank for vid_addr |

## Verification
A wrong register index, mode bit or bank register shows at once on chr_bank, combinationally, for the affected slots. It shows on the nametable side only when the wrong bit 7 sends an access to the other page. A read strobed there returns the other page's byte on the next clock. A page that was written but then corrupted, or a write that lands where no hit was flagged, stays hidden until that location is read back. The bench therefore writes both pages with different bytes at the same offset, so that every routing error turns into a data mismatch on the first read that follows.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  localparam int BANK_W   = 8;
  localparam int NREG     = 8;
  localparam int IDX_W    = $clog2(NREG);
  localparam int MODE_BIT = 7;
  localparam int PAGE_AW  = 10;
  localparam int NT_AW    = PAGE_AW + 1;
  localparam int VID_AW   = 14;
  localparam logic [2:0] WIN_TAG = 3'b100;

  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [NREG-1:0][BANK_W-1:0] bank_file_t;

  // Which register feeds a 1 KB slot; mode 1 swaps the two 4 KB halves.
  function automatic logic [IDX_W-1:0] slot_reg_idx(input logic mode, input logic [2:0] slot);
    logic [2:0] s;
    s = slot ^ {mode, 2'b00};
    if (!s[2]) return {{(IDX_W-1){1'b0}}, s[1]};
    return IDX_W'({1'b0, s[1:0]} + 3'd2);
  endfunction

  // True when the slot is half of a 2 KB pair (low bank bit forced).
  function automatic logic slot_is_pair(input logic mode, input logic [2:0] slot);
    return (slot[2] == mode);
  endfunction

  function automatic bank_t slot_bank(input bank_file_t r, input logic mode, input logic [2:0] slot);
    bank_t b;
    b = r[slot_reg_idx(mode, slot)];
    if (slot_is_pair(mode, slot)) b[0] = slot[0];
    return b;
  endfunction

  function automatic logic slot_page(input bank_file_t r, input logic mode, input logic [2:0] slot);
    bank_t b;
    b = r[slot_reg_idx(mode, slot)];
    return b[BANK_W-1];
  endfunction
endpackage

// File: rtl/nbc_cpu_regs.sv
module nbc_cpu_regs
  import nbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_we,
  input  logic [2:0]       cpu_a_top,
  input  logic             cpu_a0,
  input  logic [BANK_W-1:0] cpu_wdata,
  output bank_file_t       regs,
  output logic             chr_mode,
  output logic [IDX_W-1:0] sel_idx,
  output logic             sel_wr,
  output logic             data_wr
);
  logic            in_window;
  logic [NREG-1:0] reg_we;

  assign in_window = cpu_we && (cpu_a_top == WIN_TAG);
  assign sel_wr    = in_window && !cpu_a0;
  assign data_wr   = in_window && cpu_a0;

  for (genvar i = 0; i < NREG; i++) begin : g_we
    assign reg_we[i] = data_wr && (sel_idx == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_idx  <= '0;
      chr_mode <= 1'b0;
    end else if (sel_wr) begin
      sel_idx  <= cpu_wdata[IDX_W-1:0];
      chr_mode <= cpu_wdata[MODE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (reg_we[i]) regs[i] <= cpu_wdata;
      end
    end
  end
endmodule

// File: rtl/nbc_bank_map.sv
module nbc_bank_map
  import nbc_pkg::*;
(
  input  bank_file_t  regs,
  input  logic        chr_mode,
  input  logic [12:0] pat_addr,
  output bank_t       bank
);
  assign bank = slot_bank(regs, chr_mode, pat_addr[12:10]);
endmodule

// File: rtl/nbc_nt_route.sv
module nbc_nt_route
  import nbc_pkg::*;
(
  input  bank_file_t          regs,
  input  logic                chr_mode,
  input  logic [VID_AW-1:0]   vid_addr,
  input  logic                vid_re,
  input  logic                vid_we,
  output logic                hit,
  output logic                page,
  output logic [NT_AW-1:0]    ram_addr,
  output logic                ram_re,
  output logic                ram_we
);
  logic [VID_AW-1:0] masked;

  assign masked   = vid_addr & VID_AW'(14'h2FFF);
  assign hit      = masked[13];
  assign page     = slot_page(regs, chr_mode, masked[12:10]);
  assign ram_addr = {page, masked[PAGE_AW-1:0]};
  assign ram_re   = vid_re && hit;
  assign ram_we   = vid_we && hit;
endmodule

// File: rtl/nbc_nt_ram.sv
module nbc_nt_ram
  import nbc_pkg::*;
(
  input  logic              clk,
  input  logic              re,
  input  logic              we,
  input  logic [NT_AW-1:0]  addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << NT_AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/nbc_top.sv
module nbc_top
  import nbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_we,
  input  logic [2:0]  cpu_a_top,
  input  logic        cpu_a0,
  input  logic [7:0]  cpu_wdata,
  input  logic [13:0] vid_addr,
  input  logic        vid_re,
  input  logic        vid_we,
  input  logic [7:0]  vid_wdata,
  output logic [7:0]  vid_rdata,
  output logic        nt_hit,
  output logic [7:0]  chr_bank
);
  bank_file_t       regs;
  logic             chr_mode;
  logic [IDX_W-1:0] sel_idx;
  logic             sel_wr;
  logic             data_wr;
  logic             nt_page;
  logic [NT_AW-1:0] ram_addr;
  logic             ram_re;
  logic             ram_we;

  nbc_cpu_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_a_top(cpu_a_top),
    .cpu_a0(cpu_a0), .cpu_wdata(cpu_wdata), .regs(regs), .chr_mode(chr_mode),
    .sel_idx(sel_idx), .sel_wr(sel_wr), .data_wr(data_wr)
  );

  nbc_bank_map u_map (
    .regs(regs), .chr_mode(chr_mode), .pat_addr(vid_addr[12:0]), .bank(chr_bank)
  );

  nbc_nt_route u_route (
    .regs(regs), .chr_mode(chr_mode), .vid_addr(vid_addr), .vid_re(vid_re),
    .vid_we(vid_we), .hit(nt_hit), .page(nt_page), .ram_addr(ram_addr),
    .ram_re(ram_re), .ram_we(ram_we)
  );

  nbc_nt_ram u_ram (
    .clk(clk), .re(ram_re), .we(ram_we), .addr(ram_addr),
    .wdata(vid_wdata), .rdata(vid_rdata)
  );
endmodule

// File: rtl/nbc_checker.sv
module nbc_checker
  import nbc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_we,
  input logic [2:0]       cpu_a_top,
  input logic [7:0]       cpu_wdata,
  input logic             vid_we,
  input logic [1:0]       vid_quad,
  input logic             nt_hit,
  input bank_file_t       regs,
  input logic             chr_mode,
  input logic [IDX_W-1:0] sel_idx,
  input logic             sel_wr,
  input logic             data_wr,
  input logic             ram_we,
  input logic             nt_page
);
  bank_t sel_val;
  bank_t quad_reg_m0;
  bank_t quad_reg_m1;
  logic  foreign_wr;

  assign sel_val     = regs[sel_idx];
  assign quad_reg_m0 = vid_quad[1] ? regs[1] : regs[0];
  assign quad_reg_m1 = regs[IDX_W'({1'b0, vid_quad} + 3'd2)];
  assign foreign_wr  = cpu_we && (cpu_a_top != WIN_TAG);

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (regs == '0 && sel_idx == '0 && !chr_mode));

  a_r2_select_load: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (sel_idx == $past(cpu_wdata[IDX_W-1:0]) && chr_mode == $past(cpu_wdata[MODE_BIT])));

  a_r3_data_load: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (sel_val == $past(cpu_wdata)));

  a_r9_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    foreign_wr |=> ($stable(regs) && $stable(chr_mode) && $stable(sel_idx)));

  a_r7_page_mode0: assert property (@(posedge clk) disable iff (!rst_n)
    (nt_hit && !chr_mode) |-> (nt_page == quad_reg_m0[BANK_W-1]));

  a_r8_page_mode1: assert property (@(posedge clk) disable iff (!rst_n)
    (nt_hit && chr_mode) |-> (nt_page == quad_reg_m1[BANK_W-1]));

  a_r12_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_we && !nt_hit) |-> !ram_we);
endmodule

bind nbc_top nbc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_a_top(cpu_a_top),
  .cpu_wdata(cpu_wdata), .vid_we(vid_we), .vid_quad(vid_addr[11:10]),
  .nt_hit(nt_hit), .regs(regs), .chr_mode(chr_mode), .sel_idx(sel_idx),
  .sel_wr(sel_wr), .data_wr(data_wr), .ram_we(ram_we), .nt_page(nt_page)
);

// File: tb/nbc_top_tb.sv
module nbc_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [2:0]  cpu_a_top = 3'b000;
  logic        cpu_a0 = 1'b0;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [13:0] vid_addr = 14'h0;
  logic        vid_re = 1'b0;
  logic        vid_we = 1'b0;
  logic [7:0]  vid_wdata = 8'h00;
  logic [7:0]  vid_rdata;
  logic        nt_hit;
  logic [7:0]  chr_bank;

  int checks = 0;
  int errors = 0;

  logic [7:0] sreg [8];
  logic       smode;
  logic [2:0] sidx;
  logic [7:0] smem [2048];

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nbc_top u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_a_top(cpu_a_top), .cpu_a0(cpu_a0),
    .cpu_wdata(cpu_wdata), .vid_addr(vid_addr), .vid_re(vid_re), .vid_we(vid_we),
    .vid_wdata(vid_wdata), .vid_rdata(vid_rdata), .nt_hit(nt_hit), .chr_bank(chr_bank)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_bank(input logic [12:0] a);
    logic [2:0] slot;
    slot = a[12:10];
    if (!smode) begin
      case (slot)
        3'd0: return {sreg[0][7:1], 1'b0};
        3'd1: return {sreg[0][7:1], 1'b1};
        3'd2: return {sreg[1][7:1], 1'b0};
        3'd3: return {sreg[1][7:1], 1'b1};
        default: return sreg[slot - 3'd2];
      endcase
    end else begin
      case (slot)
        3'd4: return {sreg[0][7:1], 1'b0};
        3'd5: return {sreg[0][7:1], 1'b1};
        3'd6: return {sreg[1][7:1], 1'b0};
        3'd7: return {sreg[1][7:1], 1'b1};
        default: return sreg[slot + 3'd2];
      endcase
    end
  endfunction

  function automatic logic [10:0] exp_ram_addr(input logic [13:0] a);
    logic [1:0] q;
    logic [7:0] r;
    q = a[11:10];
    if (!smode) r = (q < 2) ? sreg[0] : sreg[1];
    else        r = sreg[q + 2];
    return {r[7], a[9:0]};
  endfunction

  task automatic clear_shadow();
    for (int i = 0; i < 8; i++) sreg[i] = 8'h00;
    smode = 1'b0;
    sidx  = 3'd0;
  endtask

  task automatic cpu_wr(input logic [15:0] addr, input logic [7:0] data);
    cpu_we = 1'b1; cpu_a_top = addr[15:13]; cpu_a0 = addr[0]; cpu_wdata = data;
    @(posedge clk);
    @(negedge clk);
    cpu_we = 1'b0;
    if (addr[15:13] == 3'b100) begin
      if (!addr[0]) begin sidx = data[2:0]; smode = data[7]; end
      else sreg[sidx] = data;
    end
  endtask

  task automatic set_reg(input logic [2:0] idx, input logic mode, input logic [7:0] val);
    cpu_wr(16'h8000, {mode, 4'b0000, idx});
    cpu_wr(16'h8001, val);
  endtask

  task automatic nt_wr(input logic [13:0] a, input logic [7:0] d);
    vid_addr = a; vid_wdata = d; vid_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    vid_we = 1'b0;
    if (a[13]) smem[exp_ram_addr(a)] = d;
  endtask

  task automatic nt_rd(input logic [13:0] a, input string req);
    vid_addr = a; vid_re = 1'b1;
    exp_q.push_back(smem[exp_ram_addr(a)]);
    tag_q.push_back(req);
    @(posedge clk);
    @(negedge clk);
    vid_re = 1'b0;
  endtask

  task automatic probe_bank(input logic [13:0] a, input string req);
    vid_addr = a;
    #1;
    check(chr_bank === exp_bank(a[12:0]), req, chr_bank, exp_bank(a[12:0]));
  endtask

  task automatic probe_hit(input logic [13:0] a, input logic exp);
    vid_addr = a;
    #1;
    check(nt_hit === exp, "R6", nt_hit, exp);
  endtask

  // Monitor: pops an expected byte for every served read.
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && vid_re && nt_hit) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 queue-empty", vid_rdata, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(vid_rdata === e, t, vid_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clear_shadow();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state seen through the bank bus
    probe_bank(14'h0000, "R1");
    probe_bank(14'h0400, "R1");
    check(chr_bank === 8'h01, "R1 pair-high", chr_bank, 8'h01);

    // R6: hit decode at window edges and the mirrored region
    probe_hit(14'h0000, 1'b0);
    probe_hit(14'h1FFF, 1'b0);
    probe_hit(14'h2000, 1'b1);
    probe_hit(14'h2FFF, 1'b1);
    probe_hit(14'h3400, 1'b1);

    // R2/R3/R10: page flips on R0 bit 7, pages hold separately
    set_reg(3'd0, 1'b0, 8'h00);
    nt_wr(14'h2000, 8'h11);
    set_reg(3'd0, 1'b0, 8'h80);
    nt_wr(14'h2000, 8'hAA);
    nt_rd(14'h2000, "R10 page1");
    probe_bank(14'h0000, "R3");
    check(chr_bank === 8'h80, "R3 reg-value", chr_bank, 8'h80);

    // R9: writes outside the register window are ignored
    cpu_wr(16'hA000, 8'h01);
    cpu_wr(16'hA001, 8'h7F);
    cpu_wr(16'hE000, 8'h85);
    nt_rd(14'h2000, "R9 page-kept");
    probe_bank(14'h0000, "R9");
    probe_bank(14'h1000, "R9");
    set_reg(3'd0, 1'b0, 8'h00);
    nt_rd(14'h2000, "R10 page0");

    // R7: mode 0 quadrant routing
    set_reg(3'd1, 1'b0, 8'h80);
    nt_wr(14'h2000, 8'h12);
    nt_wr(14'h2800, 8'h34);
    nt_rd(14'h2000, "R7 q0");
    nt_rd(14'h2400, "R7 q1");
    nt_rd(14'h2800, "R7 q2");
    nt_rd(14'h2C00, "R7 q3");

    // R8: mode 1 quadrant routing
    set_reg(3'd2, 1'b1, 8'h80);
    set_reg(3'd3, 1'b1, 8'h00);
    set_reg(3'd4, 1'b1, 8'h80);
    set_reg(3'd5, 1'b1, 8'h00);
    nt_wr(14'h2000, 8'h56);
    nt_wr(14'h2400, 8'h78);
    nt_rd(14'h2000, "R8 q0");
    nt_rd(14'h2800, "R8 q2");
    nt_rd(14'h2400, "R8 q1");
    nt_rd(14'h2C00, "R8 q3");
    nt_wr(14'h2C15, 8'h9C);
    nt_rd(14'h2415, "R8 q1-offset");

    // R4/R5: full slot maps in both modes
    set_reg(3'd0, 1'b0, 8'h14);
    set_reg(3'd1, 1'b0, 8'h21);
    set_reg(3'd2, 1'b0, 8'h30);
    set_reg(3'd3, 1'b0, 8'h41);
    set_reg(3'd4, 1'b0, 8'h52);
    set_reg(3'd5, 1'b0, 8'h63);
    set_reg(3'd6, 1'b0, 8'h7E);
    set_reg(3'd7, 1'b0, 8'h0F);
    for (int s = 0; s < 8; s++) probe_bank(14'(s * 1024 + 5), "R4");
    cpu_wr(16'h8000, 8'h80);
    for (int s = 0; s < 8; s++) probe_bank(14'(s * 1024 + 9), "R5");
    cpu_wr(16'h8000, 8'h00);
    probe_bank(14'h0000, "R2 mode-back");

    // R12: stray write strobe outside the window
    set_reg(3'd0, 1'b0, 8'h00);
    nt_wr(14'h2001, 8'h5A);
    nt_wr(14'h1001, 8'hFF);
    nt_wr(14'h0001, 8'hEE);
    nt_rd(14'h2001, "R12");

    // R11: contents survive reset
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    clear_shadow();
    @(negedge clk);
    probe_bank(14'h0800, "R1 after-reset");
    nt_rd(14'h2001, "R11");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10 pending", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule